// File: doc/BRIEF.md
# Receive FIFO Trigger and Hardware Flow Control

This block sits beside the receive FIFO of a UART that can run with either a 16-entry or a 64-entry receive FIFO. From the current FIFO fill level and the FIFO control fields, it decides when the receive-data-available interrupt is raised. The interrupt thresholds follow the FIFO depth in use, so the deeper FIFO's capacity is actually used.

It also provides hardware flow control in both directions. On the receive side, an automatic request-to-send mode clears the modem-control RTS bit when the FIFO nears full, which drives the active-low RTS pin inactive. The bit stays cleared until host software sets it again. On the transmit side, an automatic clear-to-send mode, which only the subsystem may enable, stops the transmitter at the next character boundary while the synchronized CTS pin is inactive. The transmitter restarts when CTS returns active.

The FIFO storage and the serializers are not part of this block. It sees only a fill count and a character-boundary flag.

Top module: `rx_trig_flowctl`

## Requirements
- R1: Deep (64-entry) mode is active exactly when `extend_n` is 0 and `fcr_deep_en` is 1, and `deep_mode` reports it. In deep mode, `fcr_trig_sel` values 0, 1, 2, 3 select trigger levels of 1, 16, 32 and 56 entries.
- R2: In 16-entry mode, `fcr_trig_sel` values 0, 1, 2, 3 select trigger levels of 1, 4, 8 and 14 entries.
- R3: `rx_avail_irq` is 1 in the same cycle, without a clock edge, whenever `rx_level` is at or above the selected trigger level, and 0 otherwise. The auto-RTS and auto-CTS enables have no effect on it.
- R4: Automatic RTS control is enabled only when `fcr_auto_rts` is 1 and `extend_n` is 0. While it is disabled, the fill level has no effect on `rts_bit`.
- R5: With automatic RTS enabled, a fill level of at least 14 (16-entry mode) or at least 56 (deep mode) clears `rts_bit` at the next clock edge. `rts_n` is always the inverse of `rts_bit`.
- R6: The block never sets `rts_bit` by itself. The bit changes to 1 only on a host write (`host_mcr_wr`=1 with `host_rts_wdata`=1). If the automatic clear condition holds in the same cycle as that write, the clear wins and the bit stays 0.
- R7: `auto_cts_en` is loaded only from the subsystem write port (`sub_acts_wr`, `sub_acts_wdata`) and is not changed by host writes.
- R8: With `auto_cts_en` = 1, `tx_halt` rises only at the edge that sees both `tx_char_done` = 1 and an inactive CTS (`cts_n` = 1), with `cts_n` passed through a 2-stage synchronizer. It rises 3 edges after `cts_n` goes high when `tx_char_done` is held at 1. While `tx_char_done` is 0, the halt does not start.
- R9: `tx_halt` falls one edge after the synchronized CTS is active (0), or one edge after `auto_cts_en` is 0. With auto-CTS disabled, an inactive CTS never halts the transmitter.
- R10: After a synchronous active-low reset, `rts_bit`=0, `rts_n`=1, `auto_cts_en`=0 and `tx_halt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | 7 | Current receive FIFO fill count (0..64) |
| fcr_trig_sel | input | 2 | Trigger select field of the FIFO control register |
| fcr_deep_en | input | 1 | FIFO control request for the 64-entry FIFO |
| fcr_auto_rts | input | 1 | FIFO control request for automatic RTS |
| extend_n | input | 1 | Extension strap, active low |
| host_mcr_wr | input | 1 | Host write strobe for the modem-control RTS bit |
| host_rts_wdata | input | 1 | RTS value written by the host |
| sub_acts_wr | input | 1 | Subsystem write strobe for the auto-CTS enable |
| sub_acts_wdata | input | 1 | Auto-CTS enable value written by the subsystem |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_char_done | input | 1 | Transmitter is at a character boundary |
| rx_avail_irq | output | 1 | Receive-data-available interrupt |
| rts_bit | output | 1 | Modem-control RTS register bit |
| rts_n | output | 1 | Request-to-send pin, active low |
| auto_cts_en | output | 1 | Auto-CTS enable (read-only to the host) |
| tx_halt | output | 1 | Transmitter halt request |
| deep_mode | output | 1 | 64-entry mode is active |

## Verification
Two things can happen in the same cycle. A host write that sets the RTS bit can arrive while the fill level is at or above the auto-clear threshold. Separately, the fill level can cross a trigger level that is equal to that threshold, so the interrupt and the RTS clear come from the same count. The first case is driven on purpose: a set-RTS write is issued at the same cycle that the level crosses 14 or 56. The check is that `rts_bit` reads 0 after the edge. The second case uses trigger select 3, where the interrupt must rise at once while `rts_bit` drops one edge later. Random mixes of levels, modes and host writes are compared each cycle against a bench model built from the requirements.

// File: rtl/rxfc_pkg.sv
// Shared constants and types for the receive trigger / flow-control block.
package rxfc_pkg;
    typedef enum logic {MODE_STD = 1'b0, MODE_DEEP = 1'b1} fifo_mode_e;
endpackage

// File: rtl/rxfc_trig_decode.sv
// Receive trigger decode: selects a threshold from the mode and the select
// field, and compares the fill level against it.
// Assumes rx_level never exceeds the deep FIFO depth.
module rxfc_trig_decode
    import rxfc_pkg::*;
#(
    parameter int LVL_W   = 7,
    parameter int STD_T0  = 1,
    parameter int STD_T1  = 4,
    parameter int STD_T2  = 8,
    parameter int STD_T3  = 14,
    parameter int DEEP_T0 = 1,
    parameter int DEEP_T1 = 16,
    parameter int DEEP_T2 = 32,
    parameter int DEEP_T3 = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fifo_mode_e       mode,
    input  logic [1:0]       trig_sel,
    input  logic [LVL_W-1:0] level,
    output logic             irq
);
    logic [LVL_W-1:0] thr;

    // Threshold lookup per mode and select value.
    always_comb begin
        unique case ({mode == MODE_DEEP, trig_sel})
            3'b000:  thr = LVL_W'(STD_T0);
            3'b001:  thr = LVL_W'(STD_T1);
            3'b010:  thr = LVL_W'(STD_T2);
            3'b011:  thr = LVL_W'(STD_T3);
            3'b100:  thr = LVL_W'(DEEP_T0);
            3'b101:  thr = LVL_W'(DEEP_T1);
            3'b110:  thr = LVL_W'(DEEP_T2);
            default: thr = LVL_W'(DEEP_T3);
        endcase
    end

    // Interrupt is a pure level comparison.
    assign irq = (level >= thr);

    p_deep_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DEEP && trig_sel == 2'b11 && level == LVL_W'(DEEP_T3 - 1)) |-> !irq);
    p_std_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD && trig_sel == 2'b11 && level == LVL_W'(STD_T3)) |-> irq);
    p_empty_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !irq);
endmodule

// File: rtl/rxfc_rts_ctrl.sv
// Modem-control RTS bit with automatic clear on high receive occupancy.
// Assumes host writes are single-cycle strobes; the block never sets the bit.
module rxfc_rts_ctrl
    import rxfc_pkg::*;
#(
    parameter int LVL_W    = 7,
    parameter int STD_LIM  = 14,
    parameter int DEEP_LIM = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fifo_mode_e       mode,
    input  logic             auto_en,
    input  logic [LVL_W-1:0] level,
    input  logic             host_wr,
    input  logic             host_data,
    output logic             rts_q
);
    logic [LVL_W-1:0] lim;
    logic             auto_clr;

    // Clear limit follows the active FIFO depth.
    assign lim      = (mode == MODE_DEEP) ? LVL_W'(DEEP_LIM) : LVL_W'(STD_LIM);
    assign auto_clr = auto_en && (level >= lim);

    // RTS register: automatic clear outranks a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)        rts_q <= 1'b0;
        else if (auto_clr) rts_q <= 1'b0;
        else if (host_wr)  rts_q <= host_data;
    end

    p_auto_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && level >= lim) |=> !rts_q);
    p_no_self_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_q && !(host_wr && host_data)) |=> !rts_q);
    p_off_ignores_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !host_wr) |=> $stable(rts_q));
endmodule

// File: rtl/rxfc_cts_gate.sv
// Auto-CTS gate: synchronizes CTS, holds the subsystem-owned enable, and
// halts the transmitter at a character boundary while CTS is inactive.
// Assumes cts_n is asynchronous to clk.
module rxfc_cts_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic sub_wr,
    input  logic sub_data,
    input  logic char_done,
    output logic acts_en,
    output logic halt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   cts_off;

    // Synchronizer chain, reset to the inactive level.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b1;
                else        sync_q[i] <= (i == 0) ? cts_n : sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate
    assign cts_off = sync_q[SYNC_STAGES-1];

    // Subsystem-owned enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      acts_en <= 1'b0;
        else if (sub_wr) acts_en <= sub_data;
    end

    // Halt starts at a boundary, ends when CTS returns or the mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n)                       halt <= 1'b0;
        else if (!acts_en || !cts_off)    halt <= 1'b0;
        else if (char_done)               halt <= 1'b1;
    end

    p_halt_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> ($past(char_done) && $past(acts_en)));
    p_halt_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && (!cts_off || !acts_en)) |=> !halt);
    p_halt_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acts_en |=> !halt);
endmodule

// File: rtl/rx_trig_flowctl.sv
// Top: receive trigger interrupt plus automatic RTS/CTS flow control.
// Assumes rx_level is the FIFO occupancy maintained elsewhere.
module rx_trig_flowctl
    import rxfc_pkg::*;
#(
    parameter int DEEP_DEPTH  = 64,
    parameter int SYNC_STAGES = 2,
    parameter int LVL_W       = $clog2(DEEP_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [1:0]       fcr_trig_sel,
    input  logic             fcr_deep_en,
    input  logic             fcr_auto_rts,
    input  logic             extend_n,
    input  logic             host_mcr_wr,
    input  logic             host_rts_wdata,
    input  logic             sub_acts_wr,
    input  logic             sub_acts_wdata,
    input  logic             cts_n,
    input  logic             tx_char_done,
    output logic             rx_avail_irq,
    output logic             rts_bit,
    output logic             rts_n,
    output logic             auto_cts_en,
    output logic             tx_halt,
    output logic             deep_mode
);
    localparam int DEEP_LIM = DEEP_DEPTH - DEEP_DEPTH / 8;

    fifo_mode_e mode;
    logic       auto_rts_on;

    // Mode and auto-RTS qualification from the strap and control fields.
    assign mode        = (!extend_n && fcr_deep_en) ? MODE_DEEP : MODE_STD;
    assign deep_mode   = (mode == MODE_DEEP);
    assign auto_rts_on = fcr_auto_rts && !extend_n;
    assign rts_n       = ~rts_bit;

    rxfc_trig_decode #(.LVL_W(LVL_W), .DEEP_T3(DEEP_LIM)) u_trig (
        .clk(clk), .rst_n(rst_n), .mode(mode), .trig_sel(fcr_trig_sel),
        .level(rx_level), .irq(rx_avail_irq));

    rxfc_rts_ctrl #(.LVL_W(LVL_W), .DEEP_LIM(DEEP_LIM)) u_rts (
        .clk(clk), .rst_n(rst_n), .mode(mode), .auto_en(auto_rts_on),
        .level(rx_level), .host_wr(host_mcr_wr), .host_data(host_rts_wdata),
        .rts_q(rts_bit));

    rxfc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .sub_wr(sub_acts_wr),
        .sub_data(sub_acts_wdata), .char_done(tx_char_done),
        .acts_en(auto_cts_en), .halt(tx_halt));

    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> (!rts_bit && rts_n && !auto_cts_en && !tx_halt));
    p_acts_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_acts_wr |=> $stable(auto_cts_en));
endmodule

// File: tb/rx_trig_flowctl_test.sv
module rx_trig_flowctl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic [6:0] rx_level = 0;
    logic [1:0] fcr_trig_sel = 0;
    logic fcr_deep_en = 0, fcr_auto_rts = 0, extend_n = 1;
    logic host_mcr_wr = 0, host_rts_wdata = 0, sub_acts_wr = 0, sub_acts_wdata = 0;
    logic cts_n = 0, tx_char_done = 0;
    logic rx_avail_irq, rts_bit, rts_n, auto_cts_en, tx_halt, deep_mode;
    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_trig_flowctl uut (.*);

    function automatic int exp_trig(bit deep, logic [1:0] sel);
        if (deep) return (sel == 0) ? 1 : (sel == 1) ? 16 : (sel == 2) ? 32 : 56;
        return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
    endfunction

    function automatic bit exp_deep(logic ext_n, logic deep_en);
        return !ext_n && deep_en;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(); @(posedge clk); #1; endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit mrts;
        void'($urandom(32'h5eed_0021));
        step(); step();
        rst_n = 1; #1;
        // R10 reset state
        chk(!rts_bit, "R10 rts_bit", rts_bit, 0);
        chk(rts_n, "R10 rts_n", rts_n, 1);
        chk(!auto_cts_en, "R10 auto_cts_en", auto_cts_en, 0);
        chk(!tx_halt, "R10 tx_halt", tx_halt, 0);

        // R1 R2 R3: random trigger decode, combinational compare
        for (int i = 0; i < 400; i++) begin
            bit d; int t;
            rx_level = 7'($urandom_range(0, 64));
            fcr_trig_sel = 2'($urandom);
            fcr_deep_en = 1'($urandom); extend_n = 1'($urandom);
            fcr_auto_rts = 1'($urandom);
            #1;
            d = exp_deep(extend_n, fcr_deep_en);
            t = exp_trig(d, fcr_trig_sel);
            chk(deep_mode == d, "R1 deep_mode", deep_mode, d);
            chk(rx_avail_irq == (rx_level >= t), d ? "R1 R3 irq deep" : "R2 R3 irq std",
                rx_avail_irq, rx_level >= t);
        end
        // directed trigger boundaries
        extend_n = 0; fcr_deep_en = 1; fcr_trig_sel = 3; rx_level = 55; #1;
        chk(!rx_avail_irq, "R1 deep 55 below 56", rx_avail_irq, 0);
        rx_level = 56; #1;
        chk(rx_avail_irq, "R1 deep 56", rx_avail_irq, 1);
        fcr_deep_en = 0; fcr_trig_sel = 1; rx_level = 3; #1;
        chk(!rx_avail_irq, "R2 std 3 below 4", rx_avail_irq, 0);
        rx_level = 4; #1;
        chk(rx_avail_irq, "R2 std 4", rx_avail_irq, 1);

        // R4 R5 R6: random RTS against a model
        @(negedge clk);
        mrts = rts_bit;
        for (int i = 0; i < 1500; i++) begin
            bit d, en, clr; int lim;
            rx_level = 7'($urandom_range(0, 64));
            fcr_deep_en = 1'($urandom); extend_n = 1'($urandom);
            fcr_auto_rts = 1'($urandom);
            host_mcr_wr = ($urandom_range(0, 3) == 0);
            host_rts_wdata = 1'($urandom);
            d = exp_deep(extend_n, fcr_deep_en);
            en = fcr_auto_rts && !extend_n;
            lim = d ? 56 : 14;
            clr = en && (rx_level >= lim);
            if (clr) mrts = 0; else if (host_mcr_wr) mrts = host_rts_wdata;
            step();
            chk(rts_bit == mrts, clr ? "R5 auto clear" : (en ? "R6 hold/set" : "R4 disabled"),
                rts_bit, mrts);
            chk(rts_n == !mrts, "R5 rts_n", rts_n, !mrts);
            @(negedge clk);
        end
        // R6 simultaneous set and crossing, deep
        host_mcr_wr = 1; host_rts_wdata = 1; extend_n = 0; fcr_deep_en = 1;
        fcr_auto_rts = 0; rx_level = 0; step(); @(negedge clk);
        chk(rts_bit, "R6 host set", rts_bit, 1);
        fcr_auto_rts = 1; fcr_trig_sel = 3; rx_level = 56; #1;
        chk(rx_avail_irq, "R3 irq same cycle", rx_avail_irq, 1);
        step(); @(negedge clk);
        chk(!rts_bit, "R6 clear wins over set", rts_bit, 0);
        host_mcr_wr = 0; rx_level = 0;
        for (int k = 0; k < 5; k++) step();
        chk(!rts_bit, "R6 no self set", rts_bit, 0);
        // R4 extend_n high: level ignored
        @(negedge clk); extend_n = 1; host_mcr_wr = 1; rx_level = 0; step();
        @(negedge clk); host_mcr_wr = 0; rx_level = 64; step(); step();
        chk(rts_bit, "R4 level ignored when strap high", rts_bit, 1);

        // R7: host writes do not touch auto-CTS enable
        @(negedge clk); host_mcr_wr = 1; host_rts_wdata = 1; step();
        chk(!auto_cts_en, "R7 host no effect", auto_cts_en, 0);
        @(negedge clk); host_mcr_wr = 0; sub_acts_wr = 1; sub_acts_wdata = 1; step();
        @(negedge clk); sub_acts_wr = 0;
        chk(auto_cts_en, "R7 subsystem set", auto_cts_en, 1);

        // R8: halt waits for boundary
        tx_char_done = 0; cts_n = 1;
        for (int k = 0; k < 6; k++) step();
        chk(!tx_halt, "R8 no halt mid-character", tx_halt, 0);
        @(negedge clk); tx_char_done = 1; step();
        chk(tx_halt, "R8 halt at boundary", tx_halt, 1);
        // R9 release after sync latency
        @(negedge clk); cts_n = 0; step(); step();
        chk(tx_halt, "R9 still halted during sync", tx_halt, 1);
        step();
        chk(!tx_halt, "R9 released", tx_halt, 0);
        // R8 latency with boundary held
        @(negedge clk); cts_n = 1; step(); step();
        chk(!tx_halt, "R8 before 3 edges", tx_halt, 0);
        step();
        chk(tx_halt, "R8 at 3 edges", tx_halt, 1);
        // R9 disable releases and prevents halt
        @(negedge clk); sub_acts_wr = 1; sub_acts_wdata = 0; step();
        @(negedge clk); sub_acts_wr = 0; step();
        chk(!tx_halt, "R9 disabled no halt", tx_halt, 0);
        for (int k = 0; k < 4; k++) step();
        chk(!tx_halt, "R9 disabled stays running", tx_halt, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule